// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

A synchronous single-port memory with the cycle behaviour of a pipelined burst SRAM whose bus never needs an idle cycle between a read and a write. Every cycle the controller presents one command: a load with a new address, an advance of the current burst, or a deselect. Read data leaves one enabled clock edge after its command. Write data is taken two enabled edges after its command. A read and a write can therefore follow each other in any mix at full rate on one shared data slot.

The 36-bit word is made of four 9-bit lanes. Each lane holds a data byte in bits [7:0] and a parity bit in bit 8. The lanes are written under per-lane active-low masks. A 2-bit burst counter visits the four words of an aligned group in linear order or in interleaved order, chosen by a strap input. An active-low clock enable freezes every register, so the bus master can stretch any cycle. The data path is split into an input bus, an output bus and an output-valid line, so it can be used on chip. The array depth is a parameter.

Top module: `zt_pipe_sram`

## Requirements
- R1: A load cycle (advLoad low, clkEnN low) starts an access only when csLowA is low, csHigh is high and csLowB is low. Any other select combination is a deselect: no access starts, any burst in progress ends, and no read data follows it.
- R2: While clkEnN is high, the clock edge is ignored. Every other input, including the selects, is disregarded. The pipeline, the burst state, dataOut and the registered output-valid state all hold, so the previous cycle is extended.
- R3: A read whose command is taken at enabled edge k drives its word on dataOut with dataOutEn high after enabled edge k+1, and keeps it until the next enabled edge.
- R4: A write whose command is taken at enabled edge k stores the dataIn value present at enabled edge k+2. Reads and writes may alternate on consecutive cycles with no idle cycle.
- R5: On a write, lane i (dataIn bits [9i+8:9i]) is stored only when bwN[i] is low. A lane whose bwN bit is high keeps its previous content.
- R6: With burstMode low, each advance (advLoad high) addresses the word whose low two bits are (load address low bits + count) mod 4, where count is 1, 2, 3, 0, ... for successive advances. The upper address bits stay fixed.
- R7: With burstMode high, each advance addresses the word whose low two bits are the load address low bits XOR the count.
- R8: An advance that comes after reset or after a deselect, with no load in between, starts no access.
- R9: dataOutEn is low while a write's data slot is on the bus, while the device is deselected, and on the first cycle after it leaves the deselected state. A high oeN forces dataOutEn low at once, with no clock edge.
- R10: A read of an address whose write data is taken at the same edge that registers the read returns that new data for the lanes being written, merged with the stored content of the other lanes.
- R11: A synchronous reset (rst high at a clock edge, whatever clkEnN is) cancels the pending reads and writes and drops dataOutEn. The array keeps its contents.
- R12: A burst keeps the read or write kind set by its load, whatever weN is on the advances. On a write burst, bwN is sampled on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clkEnN | input | 1 | Clock enable, active low |
| csLowA | input | 1 | Chip select, active low |
| csHigh | input | 1 | Chip select, active high |
| csLowB | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low, sampled on loads |
| advLoad | input | 1 | High: advance the burst; low: load a new address |
| bwN | input | 4 | Per-lane write masks, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| burstMode | input | 1 | Burst order strap: high interleaved, low linear |
| addr | input | $clog2(DEPTH) | Word address |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| dataOut | output | 36 | Read data |
| dataOutEn | output | 1 | Read data valid / drive enable |

## Verification
Every result is due a fixed number of enabled edges after its stimulus: read data one edge after its command, write data consumed two edges after its command, and a freshly read word visible in the cycle that follows that consumption. The only exception is oeN, which takes effect with no edge at all. The bench advances its reference memory and pipeline model only on edges where clkEnN is low, so stall cycles move no expected result forward. It compares dataOut and dataOutEn two nanoseconds after every edge, in the cycle when the counted registers have updated. The asynchronous output enable is checked between edges.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;     // enabled clock edge
    logic rdIssue;  // stage-1 holds a read
    logic wrIssue;  // stage-1 holds a write
  } ctlStrobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input burstOrder_e ord);
    return (ord == ORDER_INTERLEAVE) ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/ztsram_ctrl.sv
module ztsram_ctrl import ztsram_pkg::*; #(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clkEnN,
  input  logic             csLowA,
  input  logic             csHigh,
  input  logic             csLowB,
  input  logic             weN,
  input  logic             advLoad,
  input  logic [LANES-1:0] bwN,
  input  logic             burstMode,
  input  logic [AW-1:0]    addr,
  output ctlStrobe_t       strobe,
  output logic [AW-1:0]    s1Addr,
  output logic [LANES-1:0] s1Lanes
);
  logic          chipSel;
  logic          burstOn;
  logic          burstWr;
  logic [AW-1:0] baseAddr;
  logic [1:0]    cnt;
  logic [1:0]    nextCnt;
  logic [AW-1:0] advAddr;
  logic          s1Rd;
  logic          s1Wr;
  burstOrder_e   ord;

  assign chipSel = ~csLowA & csHigh & ~csLowB;
  assign ord     = burstOrder_e'(burstMode);
  assign nextCnt = cnt + 2'd1;
  assign advAddr = {baseAddr[AW-1:2], burstLow(baseAddr[1:0], nextCnt, ord)};

  always_ff @(posedge clk) begin
    if (rst) begin
      burstOn <= 1'b0;
      s1Rd    <= 1'b0;
      s1Wr    <= 1'b0;
    end else if (!clkEnN) begin
      if (!advLoad) begin
        if (chipSel) begin
          burstOn  <= 1'b1;
          burstWr  <= ~weN;
          baseAddr <= addr;
          cnt      <= 2'd0;
          s1Rd     <= weN;
          s1Wr     <= ~weN;
          s1Addr   <= addr;
          s1Lanes  <= ~bwN;
        end else begin
          burstOn <= 1'b0;
          s1Rd    <= 1'b0;
          s1Wr    <= 1'b0;
        end
      end else if (burstOn) begin
        cnt     <= nextCnt;
        s1Rd    <= ~burstWr;
        s1Wr    <= burstWr;
        s1Addr  <= advAddr;
        s1Lanes <= ~bwN;
      end else begin
        s1Rd <= 1'b0;
        s1Wr <= 1'b0;
      end
    end
  end

  assign strobe.step    = ~clkEnN;
  assign strobe.rdIssue = s1Rd;
  assign strobe.wrIssue = s1Wr;

  // R1
  deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !advLoad && !chipSel) |=> (!s1Rd && !s1Wr));

  // R8
  orphan_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advLoad && !burstOn) |=> (!s1Rd && !s1Wr));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> ($stable(s1Addr) && $stable(s1Rd) && $stable(s1Wr) && $stable(burstOn)));

  // R12
  burst_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advLoad && burstOn) |=> (s1Wr == $past(burstWr)));

  // R1
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({s1Rd, s1Wr}));
endmodule

// File: rtl/ztsram_datapath.sv
module ztsram_datapath import ztsram_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [AW-1:0]     s1Addr,
  input  logic [LANES-1:0]  s1Lanes,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              oeN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              s2Wr;
  logic [AW-1:0]     s2Addr;
  logic [LANES-1:0]  s2Lanes;
  logic              outVld;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] stored;
  logic [WORD_W-1:0] merged;
  logic              hit;

  assign stored = mem[s1Addr];
  assign hit    = s2Wr && (s2Addr == s1Addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = (hit && s2Lanes[i]) ?
      dataIn[i*LANE_W +: LANE_W] : stored[i*LANE_W +: LANE_W];
  end

  // Array: written on the data slot of a pending write
  always_ff @(posedge clk) begin
    if (!rst && strobe.step && s2Wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (s2Lanes[i]) mem[s2Addr][i*LANE_W +: LANE_W] <= dataIn[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Wr   <= 1'b0;
      outVld <= 1'b0;
    end else if (strobe.step) begin
      s2Wr    <= strobe.wrIssue;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
      outVld  <= strobe.rdIssue;
      if (strobe.rdIssue) rdWord <= merged;
    end
  end

  assign dataOut   = rdWord;
  assign dataOutEn = outVld & ~oeN;

  // R9
  wr_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    s2Wr |-> !dataOutEn);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.step |=> ($stable(rdWord) && $stable(outVld) && $stable(s2Wr)));

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && strobe.rdIssue) |=> outVld);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outVld && !s2Wr));
endmodule

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram import ztsram_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEnN,
  input  logic              csLowA,
  input  logic              csHigh,
  input  logic              csLowB,
  input  logic              weN,
  input  logic              advLoad,
  input  logic [3:0]        bwN,
  input  logic              oeN,
  input  logic              burstMode,
  input  logic [AW-1:0]     addr,
  input  logic [35:0]       dataIn,
  output logic [35:0]       dataOut,
  output logic              dataOutEn
);
  ctlStrobe_t       strobe;
  logic [AW-1:0]    s1Addr;
  logic [LANES-1:0] s1Lanes;

  ztsram_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .clkEnN(clkEnN),
    .csLowA(csLowA), .csHigh(csHigh), .csLowB(csLowB),
    .weN(weN), .advLoad(advLoad), .bwN(bwN), .burstMode(burstMode),
    .addr(addr), .strobe(strobe), .s1Addr(s1Addr), .s1Lanes(s1Lanes)
  );

  ztsram_datapath #(.DEPTH(DEPTH), .AW(AW)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .s1Addr(s1Addr),
    .s1Lanes(s1Lanes), .dataIn(dataIn), .oeN(oeN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/test_zt_pipe_sram.sv
module test_zt_pipe_sram;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam logic [2:0] SEL = 3'b010;  // {csLowA, csHigh, csLowB}

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkEnN = 1'b1, csLowA = 1'b1, csHigh = 1'b0, csLowB = 1'b1;
  logic weN = 1'b1, advLoad = 1'b0, oeN = 1'b0, burstMode = 1'b1;
  logic [3:0]    bwN = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0]   dataIn = '0;
  logic [35:0]   dataOut;
  logic          dataOutEn;

  always #5 clk = ~clk;

  zt_pipe_sram #(.DEPTH(DEPTH)) i_zt_pipe_sram (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .csLowA(csLowA), .csHigh(csHigh),
    .csLowB(csLowB), .weN(weN), .advLoad(advLoad), .bwN(bwN), .oeN(oeN),
    .burstMode(burstMode), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  int nChk = 0, nFail = 0, salt = 0;
  logic [35:0] refMem [DEPTH];
  // reference pipeline
  logic p1V = 0, p1W = 0, p2V = 0, mVld = 0, mAct = 0, mWr = 0;
  int   p1A = 0, p2A = 0, mBase = 0, mCnt = 0;
  logic [3:0]  p1L = 0, p2L = 0;
  logic [35:0] mOut = 0;

  function automatic logic [35:0] gen(int a, int s);
    return {4'(a + s), (32'(a) * 32'h0100_0193) ^ (32'(s) * 32'h9E37_79B9)};
  endfunction

  task automatic chkOut(string tag);
    logic expEn;
    expEn = mVld && !oeN;
    nChk++;
    if (dataOutEn !== expEn) begin
      nFail++;
      $display("FAIL %s: dataOutEn=%0b expected %0b", tag, dataOutEn, expEn);
    end else if (expEn && dataOut !== mOut) begin
      nFail++;
      $display("FAIL %s: dataOut=%h expected %h", tag, dataOut, mOut);
    end
  endtask

  task automatic step(input logic ce, input logic [2:0] cs, input logic we,
                      input logic adv, input logic [3:0] bw, input int a, input string tag);
    logic [35:0] w;
    int lo;
    clkEnN = ce; {csLowA, csHigh, csLowB} = cs; weN = we; advLoad = adv;
    bwN = bw; addr = AW'(a);
    dataIn = p2V ? gen(p2A, salt) : 36'hB_ADC0_FFEE;
    @(posedge clk);
    if (!ce) begin
      if (p1V && !p1W) begin
        w = refMem[p1A];
        if (p2V && p2A == p1A)
          for (int i = 0; i < 4; i++) if (p2L[i]) w[i*9 +: 9] = dataIn[i*9 +: 9];
        mOut = w; mVld = 1;
      end else mVld = 0;
      if (p2V)
        for (int i = 0; i < 4; i++) if (p2L[i]) refMem[p2A][i*9 +: 9] = dataIn[i*9 +: 9];
      p2V = p1V && p1W; p2A = p1A; p2L = p1L;
      if (!adv) begin
        if (cs == SEL) begin
          mAct = 1; mBase = a; mCnt = 0; mWr = !we;
          p1V = 1; p1W = !we; p1A = a; p1L = ~bw;
        end else begin
          mAct = 0; p1V = 0;
        end
      end else if (mAct) begin
        mCnt = (mCnt + 1) & 3;
        lo = burstMode ? ((mBase & 3) ^ mCnt) : (((mBase & 3) + mCnt) & 3);
        p1V = 1; p1W = mWr; p1A = (mBase & ~3) | lo; p1L = ~bw;
      end else p1V = 0;
    end
    #2;
    chkOut(tag);
  endtask

  task automatic rdLd(int a, string tag);            step(0, SEL, 1, 0, 4'hF, a, tag); endtask
  task automatic wrLd(int a, logic [3:0] bw, string tag); step(0, SEL, 0, 0, bw, a, tag); endtask
  task automatic advS(logic [3:0] bw, string tag);   step(0, SEL, 1, 1, bw, 0, tag); endtask
  task automatic stallS(string tag);                 step(1, 3'b111, 0, 0, 4'h0, 0, tag); endtask
  task automatic desel(logic [2:0] cs, string tag);  step(0, cs, 1, 0, 4'hF, 0, tag); endtask

  task automatic doReset(string tag);
    rst = 1; clkEnN = 1;
    @(posedge clk);
    p1V = 0; p2V = 0; mVld = 0; mAct = 0;
    #2;
    chkOut(tag);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R2: watchdog expired, actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (2) @(posedge clk);
    #2;
    doReset("R11");

    // Fill with back-to-back writes (R4)
    salt = 1;
    for (int a = 0; a < DEPTH; a++) wrLd(a, 4'h0, "R4");
    desel(3'b111, "R4"); desel(3'b111, "R4");

    // Alternating reads and writes, no idle slot (R3, R4, R10 at a=128)
    salt = 2;
    for (int a = 0; a < DEPTH; a++) begin
      rdLd(a, "R3");
      wrLd(DEPTH - 1 - a, 4'h0, "R4");
    end
    desel(3'b111, "R3"); desel(3'b111, "R3");

    // Linear bursts from every start offset (R6)
    burstMode = 0;
    for (int g = 0; g < 64; g++) begin
      rdLd(g * 4 + (g % 4), "R6");
      for (int k = 0; k < 3; k++) advS(4'hF, "R6");
      advS(4'hF, "R6");
    end
    desel(3'b111, "R6"); desel(3'b111, "R6");

    // Interleaved bursts (R7)
    burstMode = 1;
    for (int g = 0; g < 64; g++) begin
      rdLd(g * 4 + ((g + 1) % 4), "R7");
      for (int k = 0; k < 4; k++) advS(4'hF, "R7");
    end
    desel(3'b111, "R7"); desel(3'b111, "R7");

    // Every lane mask (R5)
    salt = 5;
    for (int m = 0; m < 16; m++) begin
      wrLd(m * 3, 4'(m), "R5");
      desel(3'b111, "R5"); desel(3'b111, "R5");
      rdLd(m * 3, "R5");
      desel(3'b111, "R5");
    end
    desel(3'b111, "R5");

    // Write bursts: kind held, mask per beat, both orders (R12)
    for (int o = 0; o < 2; o++) begin
      burstMode = o[0];
      salt = 6 + o;
      wrLd(41, 4'h0, "R12");
      advS(4'h5, "R12"); advS(4'hA, "R12"); advS(4'h3, "R12");
      rdLd(41, "R12");
      for (int k = 0; k < 3; k++) advS(4'hF, "R12");
      desel(3'b111, "R12"); desel(3'b111, "R12");
    end

    // Read while write pending, partial lanes (R10)
    salt = 10;
    for (int a = 0; a < 16; a++) begin
      wrLd(100 + a, 4'(a), "R10");
      rdLd(100 + a, "R10");
      rdLd(100 + a, "R10");
    end
    desel(3'b111, "R10"); desel(3'b111, "R10");

    // Stalls inside mixed traffic (R2)
    salt = 12;
    for (int a = 0; a < 24; a++) begin
      rdLd(a, "R2");
      stallS("R2");
      wrLd(200 + a, 4'h0, "R2");
      stallS("R2"); stallS("R2");
      rdLd(200 + a, "R2");
      advS(4'hF, "R2");
      stallS("R2");
    end
    desel(3'b111, "R2"); desel(3'b111, "R2");

    // Every non-selecting chip-select pattern, orphan advances, reselect (R1, R8, R9)
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != SEL) begin
        rdLd(5, "R1");
        desel(3'(c), "R1");
        desel(3'(c), "R1");
        advS(4'hF, "R8"); advS(4'hF, "R8");
        rdLd(6 + c, "R9");
        advS(4'hF, "R9");
        desel(3'(c), "R1");
      end
    end
    desel(3'b111, "R1");

    // Asynchronous output enable (R9)
    rdLd(7, "R9");
    advS(4'hF, "R9");
    oeN = 1; #1; chkOut("R9");
    oeN = 0; #1; chkOut("R9");
    oeN = 1; advS(4'hF, "R9");
    oeN = 0; desel(3'b111, "R9"); desel(3'b111, "R9");

    // Reset mid-pipeline keeps the array (R11)
    salt = 11;
    wrLd(9, 4'h0, "R11");
    rdLd(10, "R11");
    doReset("R11");
    advS(4'hF, "R11");
    rdLd(9, "R11"); rdLd(10, "R11");
    desel(3'b111, "R11"); desel(3'b111, "R11");

    // Full read-back sweep
    for (int a = 0; a < DEPTH; a++) rdLd(a, "R4");
    desel(3'b111, "R4"); desel(3'b111, "R4");

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule